// File: doc/BRIEF.md
# Multiplexed-Bus Host Cycle Sequencer

This block is a synchronous bus master. It sits between a simple host request port and a byte-wide peripheral on a multiplexed address/data bus. Each accepted request becomes one bus cycle with four phases. First an address phase, with the latch enable high and the register number on the three shared low pins. Then an address-hold phase, with the latch enable low. Then a strobe phase, with the read or write strobe low. Finally a data-hold phase. Each phase lasts a parameter number of system clocks. Data bits 3 to 7 have their own pins. Bits 0 to 2 share pins with the address.

After a strobe ends, the peripheral needs recovery time before the next access. That time depends on what was just done and what comes next. It is counted in arbitration periods. One arbitration period is `ARB_DIV` system clocks, or twice that when `slow_arb` is high. The block keeps a record of the last access, runs a saturating counter from the last strobe trailing edge, and holds `req_ready` low until the pending request is allowed to start. Read data is captured as the read strobe ends and is returned on a one-cycle response pulse.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, `bus_ale` is low, both output enables are low, and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `bus_ale` is high for exactly `T_ADDR` clocks. During that time `bus_cs_n` is low and `bus_ad_out` carries `req_addr` with `bus_ad_oe` high.
- R3: After `bus_ale` falls, the address stays driven on the shared pins and both strobes stay high for exactly `T_AHOLD` clocks.
- R4: A read uses `bus_rd_n` and a write uses `bus_wr_n`. The two are never low together. The strobe stays low for exactly `T_STROBE` clocks. For a write, the byte appears as `{bus_dh_out, bus_ad_out}` with both enables high, from the strobe's first cycle through the cycle after it rises.
- R5: During a read strobe, `bus_ad_oe` is low. The byte `{bus_dh_in, bus_ad_in}` present in the last strobe cycle is returned on `rsp_rdata`. `rsp_valid` is high for one cycle, the same cycle `bus_rd_n` returns high.
- R6: One arbitration period is `ARB_DIV` clocks with `slow_arb` low and `2*ARB_DIV` clocks with `slow_arb` high.
- R7: After a write to register `PTR_ADDR` (default 2), the next `bus_ale` rise comes at least 4 arbitration periods after that `bus_wr_n` rise, whatever the next access is.
- R8: A write to `PTR_ADDR` that follows a write to register `DATA_ADDR` (default 4) raises `bus_ale` at least 5 arbitration periods after the earlier `bus_wr_n` rise.
- R9: A write to `PTR_ADDR` that follows a read of `DATA_ADDR` raises `bus_ale` at least 5 arbitration periods after the earlier `bus_rd_n` rise.
- R10: Every other pair of accesses is spaced at least `BASE_GAP` clocks from strobe rise to the next `bus_ale` rise. A request held ready starts with the smallest spacing allowed: the larger of the rule in force and `T_DHOLD+1` clocks.
- R11: `req_ready` is low whenever `bus_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_arb | input | 1 | Doubles the arbitration period when high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Peripheral register number |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request may be accepted this cycle |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 8 | Read byte |
| bus_ale | output | 1 | Address latch enable; peripheral latches on its fall |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_ad_out | output | 3 | Shared address/data bits 0..2, driven value |
| bus_ad_oe | output | 1 | Output enable for the shared pins |
| bus_ad_in | input | 3 | Shared pins, sampled value |
| bus_dh_out | output | 5 | Data bits 3..7, driven value |
| bus_dh_oe | output | 1 | Output enable for data bits 3..7 |
| bus_dh_in | input | 5 | Data bits 3..7, sampled value |

## Verification
Two functions can land in the same cycle. The first is expiry of the recovery count, which can happen in the same cycle a request is waiting, so `req_ready` rises and the request is taken together. The second is the read strobe's trailing edge, which captures data, pulses the response and restarts the recovery count on one edge. The bench keeps the next request pending before the previous strobe ends, for every ordered pair the rules name, with slow arbitration both off and on. It then checks that the strobe-to-latch-enable spacing equals the smallest legal value exactly: one clock late or one clock early is reported. The read response is judged against the strobe edge seen on the pins and against a byte value the bench tracks independently.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef logic [15:0] cnt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHOLD,
    ST_STROBE,
    ST_DHOLD
  } phase_e;

  // kind of the access whose strobe ended last
  typedef enum logic [2:0] {
    PK_NONE,
    PK_PTR_WR,
    PK_DATA_WR,
    PK_DATA_RD,
    PK_OTHER
  } acc_kind_e;

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] data;
  } host_op_t;

  function automatic acc_kind_e classify(input logic wr, input logic [2:0] addr,
                                         input logic [2:0] ptr_addr,
                                         input logic [2:0] data_addr);
    if (wr && addr == ptr_addr) return PK_PTR_WR;
    if (addr == data_addr) return wr ? PK_DATA_WR : PK_DATA_RD;
    return PK_OTHER;
  endfunction

  // system clocks in one arbitration period
  function automatic int unsigned arb_clocks(input int unsigned div, input logic slow);
    return slow ? 2 * div : div;
  endfunction

  // clocks from strobe trailing edge to start of the next cycle
  function automatic cnt_t recovery_need(input acc_kind_e prev, input logic nxt_ptr_wr,
                                         input int unsigned arb, input int unsigned base);
    int unsigned n;
    n = base;
    if (prev == PK_PTR_WR && 4 * arb > n) n = 4 * arb;
    if ((prev == PK_DATA_WR || prev == PK_DATA_RD) && nxt_ptr_wr && 5 * arb > n) n = 5 * arb;
    return cnt_t'(n);
  endfunction

  function automatic cnt_t phase_load(input int unsigned t);
    return (t == 0) ? cnt_t'(0) : cnt_t'(t - 1);
  endfunction

endpackage

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
  import mbs_pkg::*;
#(
  parameter int unsigned T_ADDR   = 2,
  parameter int unsigned T_AHOLD  = 2,
  parameter int unsigned T_STROBE = 3,
  parameter int unsigned T_DHOLD  = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  host_op_t req_op,
  output phase_e   phase,
  output host_op_t op,
  output logic     strobe_end
);

  cnt_t cnt;
  logic last;

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      ST_ADDR:   return ST_AHOLD;
      ST_AHOLD:  return ST_STROBE;
      ST_STROBE: return ST_DHOLD;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic int unsigned dwell(input phase_e p);
    case (p)
      ST_ADDR:   return T_ADDR;
      ST_AHOLD:  return T_AHOLD;
      ST_STROBE: return T_STROBE;
      ST_DHOLD:  return T_DHOLD;
      default:   return 1;
    endcase
  endfunction

  assign last       = (cnt == '0);
  assign strobe_end = (phase == ST_STROBE) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      op    <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (accept) begin
            phase <= ST_ADDR;
            cnt   <= phase_load(T_ADDR);
            op    <= req_op;
          end
        end
        default: begin
          if (!last) begin
            cnt <= cnt - cnt_t'(1);
          end else begin
            phase <= next_phase(phase);
            cnt   <= phase_load(dwell(next_phase(phase)));
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mbs_gap_timer.sv
module mbs_gap_timer
  import mbs_pkg::*;
#(
  parameter int unsigned ARB_DIV   = 2,
  parameter int unsigned BASE_GAP  = 2,
  parameter logic [2:0]  PTR_ADDR  = 3'd2,
  parameter logic [2:0]  DATA_ADDR = 3'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_end,
  input  logic       done_wr,
  input  logic [2:0] done_addr,
  input  logic       nxt_wr,
  input  logic [2:0] nxt_addr,
  input  logic       slow_arb,
  output logic       gap_ok
);

  localparam int unsigned RULE_MAX = 10 * ARB_DIV;
  localparam int unsigned GAP_MAX  = (BASE_GAP > RULE_MAX) ? BASE_GAP : RULE_MAX;

  cnt_t      since;
  cnt_t      need;
  acc_kind_e prev_kind;
  logic      nxt_ptr_wr;

  assign nxt_ptr_wr = nxt_wr && (nxt_addr == PTR_ADDR);
  assign need       = recovery_need(prev_kind, nxt_ptr_wr, arb_clocks(ARB_DIV, slow_arb), BASE_GAP);
  assign gap_ok     = (since >= need);

  // since = 1 in the first cycle after the strobe trailing edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since     <= cnt_t'(GAP_MAX);
      prev_kind <= PK_NONE;
    end else if (strobe_end) begin
      since     <= cnt_t'(1);
      prev_kind <= classify(done_wr, done_addr, PTR_ADDR, DATA_ADDR);
    end else if (since < cnt_t'(GAP_MAX)) begin
      since <= since + cnt_t'(1);
    end
  end

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  host_op_t   op,
  input  logic       strobe_end,
  input  logic [2:0] ad_in,
  input  logic [4:0] dh_in,
  output logic       ale,
  output logic       cs_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic [2:0] ad_out,
  output logic       ad_oe,
  output logic [4:0] dh_out,
  output logic       dh_oe,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata
);

  logic addr_ph, data_ph, strobe_ph, wr_data;

  always_comb begin
    addr_ph   = (phase == ST_ADDR) || (phase == ST_AHOLD);
    strobe_ph = (phase == ST_STROBE);
    data_ph   = strobe_ph || (phase == ST_DHOLD);
    wr_data   = data_ph && op.wr;

    ale  = (phase == ST_ADDR);
    cs_n = (phase == ST_IDLE);
    rd_n = !(strobe_ph && !op.wr);
    wr_n = !(strobe_ph && op.wr);

    // shared pins: address first, then write data; released for reads
    ad_oe  = addr_ph || wr_data;
    ad_out = addr_ph ? op.addr : (wr_data ? op.data[2:0] : 3'd0);
    dh_oe  = wr_data;
    dh_out = wr_data ? op.data[7:3] : 5'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= strobe_end && !op.wr;
      if (strobe_end && !op.wr) rsp_rdata <= {dh_in, ad_in};
    end
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int unsigned T_ADDR    = 2,
  parameter int unsigned T_AHOLD   = 2,
  parameter int unsigned T_STROBE  = 3,
  parameter int unsigned T_DHOLD   = 1,
  parameter int unsigned ARB_DIV   = 2,
  parameter int unsigned BASE_GAP  = 2,
  parameter logic [2:0]  PTR_ADDR  = 3'd2,
  parameter logic [2:0]  DATA_ADDR = 3'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_arb,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [2:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       bus_ale,
  output logic       bus_cs_n,
  output logic       bus_rd_n,
  output logic       bus_wr_n,
  output logic [2:0] bus_ad_out,
  output logic       bus_ad_oe,
  input  logic [2:0] bus_ad_in,
  output logic [4:0] bus_dh_out,
  output logic       bus_dh_oe,
  input  logic [4:0] bus_dh_in
);

  phase_e     phase;
  host_op_t   cur_op;
  host_op_t   req_op;
  logic       strobe_end;
  logic       acc_fire;
  logic       gap_ok;
  logic       cur_wr;
  logic [2:0] cur_addr;

  assign req_op    = '{wr: req_write, addr: req_addr, data: req_wdata};
  // ready looks at the pending request: only the pairs that need recovery wait for it
  assign req_ready = (phase == ST_IDLE) && gap_ok;
  assign acc_fire  = req_valid && req_ready;
  assign cur_wr    = cur_op.wr;
  assign cur_addr  = cur_op.addr;

  mbs_phase_fsm #(
    .T_ADDR  (T_ADDR),
    .T_AHOLD (T_AHOLD),
    .T_STROBE(T_STROBE),
    .T_DHOLD (T_DHOLD)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (acc_fire),
    .req_op    (req_op),
    .phase     (phase),
    .op        (cur_op),
    .strobe_end(strobe_end)
  );

  mbs_gap_timer #(
    .ARB_DIV  (ARB_DIV),
    .BASE_GAP (BASE_GAP),
    .PTR_ADDR (PTR_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_end(strobe_end),
    .done_wr   (cur_wr),
    .done_addr (cur_addr),
    .nxt_wr    (req_write),
    .nxt_addr  (req_addr),
    .slow_arb  (slow_arb),
    .gap_ok    (gap_ok)
  );

  mbs_pin_drive u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .op        (cur_op),
    .strobe_end(strobe_end),
    .ad_in     (bus_ad_in),
    .dh_in     (bus_dh_in),
    .ale       (bus_ale),
    .cs_n      (bus_cs_n),
    .rd_n      (bus_rd_n),
    .wr_n      (bus_wr_n),
    .ad_out    (bus_ad_out),
    .ad_oe     (bus_ad_oe),
    .dh_out    (bus_dh_out),
    .dh_oe     (bus_dh_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int unsigned ARB_DIV   = 2,
  parameter int unsigned BASE_GAP  = 2,
  parameter logic [2:0]  PTR_ADDR  = 3'd2,
  parameter logic [2:0]  DATA_ADDR = 3'd4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       slow_arb,
  input logic       req_ready,
  input logic       ale,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [2:0] ad_out,
  input logic       ad_oe,
  input logic       op_wr,
  input logic [2:0] op_addr
);

  logic        strobe_on, strobe_was;
  logic [15:0] gap_c;
  logic        kp_ptr_wr, kp_data;
  logic [31:0] arb, gap_w;

  assign strobe_on = !rd_n || !wr_n;
  assign arb       = slow_arb ? 32'(2 * ARB_DIV) : 32'(ARB_DIV);
  assign gap_w     = {16'd0, gap_c};

  // own count from the strobe trailing edge seen on the pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_was <= 1'b0;
      gap_c      <= 16'hFFFF;
      kp_ptr_wr  <= 1'b0;
      kp_data    <= 1'b0;
    end else begin
      strobe_was <= strobe_on;
      if (strobe_was && !strobe_on) begin
        gap_c     <= 16'd1;
        kp_ptr_wr <= op_wr && (op_addr == PTR_ADDR);
        kp_data   <= (op_addr == DATA_ADDR);
      end else if (gap_c != 16'hFFFF) begin
        gap_c <= gap_c + 16'd1;
      end
    end
  end

  assert_addr_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!cs_n && ad_oe && ad_out == op_addr));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (rd_n && wr_n && ad_oe && ad_out == op_addr));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> wr_n);

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6: the arbitration period used below doubles with slow_arb
  assert_ptr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && kp_ptr_wr) |-> (gap_w >= 4 * arb));

  // covers R8 and R9: previous access touched the data register
  assert_data_ptr_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && kp_data && op_wr && op_addr == PTR_ADDR) |-> (gap_w >= 5 * arb));

  assert_base_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (gap_w >= 32'(BASE_GAP)));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

endmodule

bind mux_bus_seq mbs_checker #(
  .ARB_DIV  (ARB_DIV),
  .BASE_GAP (BASE_GAP),
  .PTR_ADDR (PTR_ADDR),
  .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_arb (slow_arb),
  .req_ready(req_ready),
  .ale      (bus_ale),
  .cs_n     (bus_cs_n),
  .rd_n     (bus_rd_n),
  .wr_n     (bus_wr_n),
  .ad_out   (bus_ad_out),
  .ad_oe    (bus_ad_oe),
  .op_wr    (cur_wr),
  .op_addr  (cur_addr)
);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;

  localparam int T_ADDR   = 2;
  localparam int T_AHOLD  = 2;
  localparam int T_STROBE = 3;
  localparam int T_DHOLD  = 1;
  localparam int ARB_DIV  = 2;
  localparam int BASE_GAP = 2;
  localparam logic [2:0] PTR  = 3'd2;
  localparam logic [2:0] DATA = 3'd4;

  logic clk = 0, rst_n = 0, slow_arb = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic bus_ale, bus_cs_n, bus_rd_n, bus_wr_n, bus_ad_oe, bus_dh_oe;
  logic [2:0] bus_ad_out, bus_ad_in;
  logic [4:0] bus_dh_out, bus_dh_in;

  always #2.5 clk = ~clk;

  mux_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .slow_arb(slow_arb),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_dh_out(bus_dh_out), .bus_dh_oe(bus_dh_oe), .bus_dh_in(bus_dh_in)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // peripheral model and host-side expectation
  logic [7:0] pmem [8];
  logic [7:0] hmem [8];
  logic [2:0] lat_addr = 0;
  assign {bus_dh_in, bus_ad_in} = (!bus_rd_n) ? pmem[lat_addr] : 8'h00;

  bit q_w[$];
  logic [2:0] q_a[$];
  logic [7:0] q_d[$];
  bit q_t[$];
  logic [7:0] q_rd[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      chk(0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  // spacing rule restated in arbitration units
  function automatic int bench_gap(bit pw, bit pdata, bit nw, logic [2:0] na, bit slow);
    int units, clocks, m;
    units = 0;
    if (pw) units = 4;
    else if (pdata && nw && na == PTR) units = 5;
    clocks = units * ARB_DIV * (slow ? 2 : 1);
    m = clocks;
    if (BASE_GAP > m) m = BASE_GAP;
    if (T_DHOLD + 1 > m) m = T_DHOLD + 1;
    return m;
  endfunction

  bit p_ale, p_str, s_now, have_prev, pv_ptr_wr, pv_data, pv_dwr;
  logic [2:0] p_lo;
  logic [4:0] p_dh;
  bit cur_w, cur_t;
  logic [2:0] cur_a;
  logic [7:0] cur_d, exp_rd;
  int t_ale_r, t_ale_f, t_str_f, t_str_r, g, e;
  string tag;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      s_now = !bus_rd_n || !bus_wr_n;
      if (bus_ale && !p_ale) begin
        if (q_w.size() == 0) chk(0, "R2", 0, 1);
        else begin
          cur_w = q_w.pop_front(); cur_a = q_a.pop_front();
          cur_d = q_d.pop_front(); cur_t = q_t.pop_front();
        end
        t_ale_r = cyc;
        chk(!bus_cs_n && bus_ad_oe && bus_ad_out == cur_a, "R2", int'(bus_ad_out), int'(cur_a));
        if (have_prev) begin
          g = cyc - t_str_r;
          e = bench_gap(pv_ptr_wr, pv_data, cur_w, cur_a, slow_arb);
          if (pv_ptr_wr) tag = "R7 R6";
          else if (pv_data && cur_w && cur_a == PTR) tag = pv_dwr ? "R8 R6" : "R9 R6";
          else tag = "R10";
          if (cur_t) chk(g == e, tag, g, e);
          else chk(g >= e, tag, g, e);
        end
      end
      if (!bus_ale && p_ale) begin
        chk(cyc - t_ale_r == T_ADDR, "R2", cyc - t_ale_r, T_ADDR);
        lat_addr = p_lo;
        t_ale_f = cyc;
      end
      if (s_now && !p_str) begin
        chk(cyc - t_ale_f == T_AHOLD, "R3", cyc - t_ale_f, T_AHOLD);
        chk(cur_w ? (!bus_wr_n && bus_rd_n) : (!bus_rd_n && bus_wr_n), "R4",
            int'({bus_rd_n, bus_wr_n}), cur_w ? 2 : 1);
        if (cur_w) chk(bus_ad_oe && bus_dh_oe && {bus_dh_out, bus_ad_out} == cur_d, "R4",
                       int'({bus_dh_out, bus_ad_out}), int'(cur_d));
        else chk(!bus_ad_oe, "R5", int'(bus_ad_oe), 0);
        t_str_f = cyc;
      end
      if (!s_now && p_str) begin
        chk(cyc - t_str_f == T_STROBE, "R4", cyc - t_str_f, T_STROBE);
        if (cur_w) begin
          pmem[lat_addr] = {p_dh, p_lo};
          chk(bus_ad_oe && bus_dh_oe && {bus_dh_out, bus_ad_out} == cur_d, "R4 hold",
              int'({bus_dh_out, bus_ad_out}), int'(cur_d));
        end
        t_str_r = cyc;
        have_prev = 1;
        pv_ptr_wr = cur_w && cur_a == PTR;
        pv_data = (cur_a == DATA);
        pv_dwr = cur_w;
      end
      if (rsp_valid) begin
        chk(!s_now && p_str, "R5", int'(s_now), 0);
        exp_rd = (q_rd.size() > 0) ? q_rd.pop_front() : 8'hxx;
        chk(rsp_rdata == exp_rd, "R5", int'(rsp_rdata), int'(exp_rd));
      end
      if (!bus_cs_n) chk(!req_ready, "R11", int'(req_ready), 0);
      p_ale = bus_ale; p_str = s_now; p_lo = bus_ad_out; p_dh = bus_dh_out;
    end else begin
      p_ale = 0; p_str = 0;
    end
  end

  task automatic issue(input bit w, input logic [2:0] a, input logic [7:0] d, input bit tight);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    q_w.push_back(w); q_a.push_back(a); q_d.push_back(d); q_t.push_back(tight);
    if (w) hmem[a] = d;
    else q_rd.push_back(hmem[a]);
    forever begin
      #1;
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req_valid = 0;
  endtask

  task automatic burst();
    issue(1, PTR, 8'h05, 0);   // first of burst
    issue(0, 3'd1, 8'h00, 1);  // R7: pointer write then read
    issue(1, DATA, 8'hA5, 1);  // R10
    issue(1, PTR, 8'h06, 1);   // R8: data write then pointer write
    issue(1, PTR, 8'h07, 1);   // R7: pointer write twice
    issue(0, DATA, 8'h00, 1);  // R7
    issue(1, PTR, 8'h08, 1);   // R9: data read then pointer write
    issue(0, DATA, 8'h00, 1);  // R7
    issue(1, 3'd6, 8'h3C, 1);  // R10
    issue(0, 3'd6, 8'h00, 1);  // R5 read back
    issue(1, 3'd0, 8'hFF, 1);  // R10
    issue(0, 3'd0, 8'h00, 1);  // R5
    issue(0, 3'd7, 8'h00, 1);  // R5 initial contents
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      pmem[i] = 8'h30 + 8'(i);
      hmem[i] = 8'h30 + 8'(i);
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_ale, "R1",
        int'({bus_cs_n, bus_rd_n, bus_wr_n, bus_ale}), 14);
    chk(!bus_ad_oe && !bus_dh_oe, "R1", int'({bus_ad_oe, bus_dh_oe}), 0);
    chk(req_ready, "R1", int'(req_ready), 1);
    rst_n = 1;
    for (int s = 0; s < 2; s++) begin
      repeat (30) @(negedge clk);
      slow_arb = s[0];   // R6: both arbitration settings
      repeat (5) @(negedge clk);
      burst();
      repeat (40) @(negedge clk);
    end
    chk(q_w.size() == 0 && q_rd.size() == 0, "R5", q_w.size() + q_rd.size(), 0);
    finish_run();
  end

endmodule